// File: doc/BRIEF.md
# Serial LED Status Shifter

This block drives a two-wire serial link (a shift clock and a data line) into a chain of external shift registers that light a bank of status LEDs. At a fixed cadence it takes a snapshot of the switch status: one LED per port, a congestion LED, a fault LED and a row of LEDs set by software. It sends that snapshot as one burst of shift-clock pulses, one pulse per LED, and then leaves the link idle until the next burst is due. The data line is active low, so a lit LED travels as a 0.

Each port LED has three states. It is dark when the port has no link. It is steady when the link is up and the port was quiet. It blinks when the port carried traffic in the last completed activity window, and the blink phase flips at each window boundary. The fault LED combines a latched checksum-error flag, a latched memory-parity flag and a software fault bit. Each latched flag holds until its own clear pulse or a reset. A lamp-test input lights every LED.

All timing is counted in cycles of the system clock. The shift-clock high and low times are given in system cycles. The burst cadence and the activity window are given in whole shift-clock periods, so both stay tied to the same phase divider. The block has no data stream in or out, so every pin is a plain level or pulse and none uses a handshake.

Top module: `led_status_shifter`

## Requirements
- R1: While rst_n is low, led_data is held at 1 and led_clk keeps toggling, high for CLK_HI_CYC cycles and low for CLK_LO_CYC cycles.
- R2: Every burst has exactly FRAME_W = NUM_PORTS+2+NUM_SW rising edges of led_clk. Each pulse is high for CLK_HI_CYC cycles, and rising edges are CLK_HI_CYC+CLK_LO_CYC cycles apart.
- R3: Bursts start every BURST_PERIODS shift-clock periods, counted from reset release. Between bursts led_clk is 0 and led_data is 1.
- R4: led_data changes only when led_clk falls and stays stable while led_clk is high. A lit LED is sent as 0 and a dark LED as 1.
- R5: The k-th rising edge of a burst carries slot k. Slots 0 to NUM_PORTS-1 are the ports in ascending order, slot NUM_PORTS is congestion, slot NUM_PORTS+1 is fault, and the remaining slots are sw_leds bit 0 upward.
- R6: A port slot is dark when port_link is 0. With the link up it is lit when the port was quiet. When the port had activity, it is lit only while the blink phase is on. The blink phase is on after reset and flips at every window end.
- R7: Windows are WINDOW_PERIODS shift-clock periods long, counted from reset release. A port counts as active when port_act pulsed in the last window that closed strictly before the burst's start instant. A window closing at that same instant counts toward later bursts, and activity in any earlier window is forgotten.
- R8: A crc_err_set pulse latches the checksum flag. Only crc_err_clr or reset clears it, and a set in the same cycle as a clear wins.
- R9: A par_err_set pulse latches the parity flag. Only par_err_clr or reset clears it, and a set in the same cycle as a clear wins.
- R10: The fault slot is lit when either latched flag or sw_fault is 1.
- R11: The congestion slot follows flow_active and each software slot follows its sw_leds bit, sampled at the burst start instant.
- R12: With lamp_test at 1 at the burst start instant, every slot is lit (all FRAME_W data bits are 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_link | input | NUM_PORTS | Link-up level per port |
| port_act | input | NUM_PORTS | One-cycle traffic pulse per port |
| flow_active | input | 1 | Congestion indication level |
| crc_err_set | input | 1 | Pulse: configuration checksum error seen |
| crc_err_clr | input | 1 | Pulse: clear the checksum flag |
| par_err_set | input | 1 | Pulse: memory parity error seen |
| par_err_clr | input | 1 | Pulse: clear the parity flag |
| sw_fault | input | 1 | Software fault level |
| sw_leds | input | NUM_SW | Software-driven LED levels |
| lamp_test | input | 1 | Force every LED lit |
| led_clk | output | 1 | Serial shift clock |
| led_data | output | 1 | Serial LED data, active low |

## Verification
A wrong phase count or bit counter shows up inside the first burst after reset: the spacing between edges or the pulse width is off, or the burst has the wrong number of edges. A cadence counter that is off moves the start of the next burst by whole shift-clock periods. A bad window or blink state does not show as a wrong pulse. It shows as a port slot that is lit or dark wrongly, one burst later. Flag errors persist across bursts, so a flag that fails to latch or to clear is wrong in every later burst until the next clear.

// File: rtl/led_pkg.sv
package led_pkg;

  typedef enum logic [0:0] {
    SEQ_IDLE  = 1'b0,
    SEQ_SHIFT = 1'b1
  } seq_state_t;

  // lit decision for a port LED: dark without link, blink when active
  function automatic logic port_lit(input logic link, input logic active,
                                    input logic blink_on);
    return link & (~active | blink_on);
  endfunction

  function automatic logic slot_lit(input logic lamp, input logic on);
    return lamp | on;
  endfunction

endpackage

// File: rtl/led_phase_div.sv
module led_phase_div #(
  parameter int HI_CYC = 2,
  parameter int LO_CYC = 3
) (
  input  logic clk,
  output logic hi_phase,
  output logic period_end
);
  localparam int PER = HI_CYC + LO_CYC;
  localparam int PW  = (PER > 2) ? $clog2(PER) : 1;

  // free-running phase: keeps the shift clock alive through reset
  logic [PW-1:0] ph;

  always_ff @(posedge clk) begin
    if (ph >= PW'(PER - 1)) ph <= '0;
    else                    ph <= ph + 1'b1;
  end

  assign hi_phase   = (ph >= PW'(LO_CYC)) && (ph <= PW'(PER - 1));
  assign period_end = (ph == PW'(PER - 1));
endmodule

// File: rtl/led_activity.sv
module led_activity #(
  parameter int NP          = 34,
  parameter int WIN_PERIODS = 625000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          period_end,
  input  logic [NP-1:0] act_pulse,
  output logic [NP-1:0] act_recent,
  output logic          blink_on
);
  localparam int WW = (WIN_PERIODS > 2) ? $clog2(WIN_PERIODS) : 1;

  logic [WW-1:0] wcnt;
  logic [NP-1:0] seen;
  logic          win_end;

  assign win_end = period_end && (wcnt == WW'(WIN_PERIODS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt       <= '0;
      blink_on   <= 1'b1;
      seen       <= '0;
      act_recent <= '0;
    end else begin
      if (period_end) begin
        if (win_end) wcnt <= '0;
        else         wcnt <= wcnt + 1'b1;
      end
      if (win_end) begin
        blink_on   <= ~blink_on;
        act_recent <= seen | act_pulse;
        seen       <= '0;
      end else begin
        seen <= seen | act_pulse;
      end
    end
  end
endmodule

// File: rtl/led_fault_latch.sv
module led_fault_latch #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  input  logic            sw_fault,
  output logic [NSRC-1:0] flag_o,
  output logic            fault_lit
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_o <= '0;
    end else begin
      for (int s = 0; s < NSRC; s++) begin
        if (set_i[s])      flag_o[s] <= 1'b1;   // set wins over clear
        else if (clr_i[s]) flag_o[s] <= 1'b0;
      end
    end
  end

  assign fault_lit = (|flag_o) | sw_fault;
endmodule

// File: rtl/led_burst_seq.sv
module led_burst_seq
  import led_pkg::*;
#(
  parameter int FW            = 48,
  parameter int BURST_PERIODS = 620000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hi_phase,
  input  logic          period_end,
  input  logic [FW-1:0] frame,
  output logic          busy,
  output logic          led_clk,
  output logic          led_data
);
  localparam int BW = (BURST_PERIODS > 2) ? $clog2(BURST_PERIODS) : 1;
  localparam int CW = (FW > 2) ? $clog2(FW) : 1;

  seq_state_t    st;
  logic [BW-1:0] pcnt;
  logic [CW-1:0] bcnt;
  logic [FW-1:0] shreg;
  logic          start;

  assign start = period_end && (pcnt == BW'(BURST_PERIODS - 1));
  assign busy  = (st == SEQ_SHIFT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= SEQ_IDLE;
      pcnt     <= '0;
      bcnt     <= '0;
      shreg    <= '0;
      led_clk  <= hi_phase;   // keep clocking through reset
      led_data <= 1'b1;
    end else begin
      if (period_end) begin
        if (start) pcnt <= '0;
        else       pcnt <= pcnt + 1'b1;
      end
      unique case (st)
        SEQ_IDLE: begin
          if (start) begin
            st    <= SEQ_SHIFT;
            shreg <= frame;
            bcnt  <= '0;
          end
        end
        SEQ_SHIFT: begin
          if (period_end) begin
            if (bcnt == CW'(FW - 1)) st <= SEQ_IDLE;
            else                     bcnt <= bcnt + 1'b1;
            shreg <= shreg >> 1;
          end
        end
        default: st <= SEQ_IDLE;
      endcase
      led_clk  <= busy && hi_phase;
      led_data <= busy ? ~shreg[0] : 1'b1;
    end
  end
endmodule

// File: rtl/led_status_shifter.sv
module led_status_shifter
  import led_pkg::*;
#(
  parameter int NUM_PORTS      = 34,
  parameter int NUM_SW         = 12,
  parameter int CLK_HI_CYC     = 2,
  parameter int CLK_LO_CYC     = 3,
  parameter int BURST_PERIODS  = 620000,
  parameter int WINDOW_PERIODS = 625000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] port_link,
  input  logic [NUM_PORTS-1:0] port_act,
  input  logic                 flow_active,
  input  logic                 crc_err_set,
  input  logic                 crc_err_clr,
  input  logic                 par_err_set,
  input  logic                 par_err_clr,
  input  logic                 sw_fault,
  input  logic [NUM_SW-1:0]    sw_leds,
  input  logic                 lamp_test,
  output logic                 led_clk,
  output logic                 led_data
);
  localparam int FRAME_W   = NUM_PORTS + 2 + NUM_SW;
  localparam int SLOT_FLOW = NUM_PORTS;
  localparam int SLOT_FLT  = NUM_PORTS + 1;
  localparam int SLOT_SW   = NUM_PORTS + 2;

  logic                 hi_phase, period_end;
  logic [NUM_PORTS-1:0] act_recent;
  logic                 blink_on;
  logic [1:0]           flt_flags;
  logic                 crc_flag, par_flag;
  logic                 fault_lit;
  logic                 seq_busy;
  logic [FRAME_W-1:0]   frame;

  led_phase_div #(.HI_CYC(CLK_HI_CYC), .LO_CYC(CLK_LO_CYC)) u_div (
    .clk(clk), .hi_phase(hi_phase), .period_end(period_end)
  );

  led_activity #(.NP(NUM_PORTS), .WIN_PERIODS(WINDOW_PERIODS)) u_act (
    .clk(clk), .rst_n(rst_n), .period_end(period_end),
    .act_pulse(port_act), .act_recent(act_recent), .blink_on(blink_on)
  );

  led_fault_latch #(.NSRC(2)) u_flt (
    .clk(clk), .rst_n(rst_n),
    .set_i({par_err_set, crc_err_set}),
    .clr_i({par_err_clr, crc_err_clr}),
    .sw_fault(sw_fault), .flag_o(flt_flags), .fault_lit(fault_lit)
  );

  assign crc_flag = flt_flags[0];
  assign par_flag = flt_flags[1];

  for (genvar k = 0; k < NUM_PORTS; k++) begin : g_port_slot
    assign frame[k] = slot_lit(lamp_test,
                               port_lit(port_link[k], act_recent[k], blink_on));
  end

  assign frame[SLOT_FLOW] = slot_lit(lamp_test, flow_active);
  assign frame[SLOT_FLT]  = slot_lit(lamp_test, fault_lit);

  for (genvar j = 0; j < NUM_SW; j++) begin : g_sw_slot
    assign frame[SLOT_SW + j] = slot_lit(lamp_test, sw_leds[j]);
  end

  led_burst_seq #(.FW(FRAME_W), .BURST_PERIODS(BURST_PERIODS)) u_seq (
    .clk(clk), .rst_n(rst_n), .hi_phase(hi_phase), .period_end(period_end),
    .frame(frame), .busy(seq_busy), .led_clk(led_clk), .led_data(led_data)
  );
endmodule

// File: rtl/led_status_shifter_chk.sv
module led_status_shifter_chk #(
  parameter int FW     = 48,
  parameter int HI_CYC = 2
) (
  input logic clk,
  input logic rst_n,
  input logic led_clk,
  input logic led_data,
  input logic busy,
  input logic crc_set,
  input logic crc_clr,
  input logic crc_flag,
  input logic par_set,
  input logic par_clr,
  input logic par_flag
);
  localparam logic [7:0] HI_LIM = 8'(HI_CYC);
  localparam logic [7:0] FW_LIM = 8'(FW);

  logic [7:0] hi_run;
  logic [7:0] rises;
  logic       clk_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_run <= '0;
      rises  <= '0;
      clk_d  <= 1'b0;
    end else begin
      clk_d  <= led_clk;
      hi_run <= led_clk ? hi_run + 8'd1 : 8'd0;
      if (!busy)                  rises <= '0;
      else if (led_clk && !clk_d) rises <= rises + 8'd1;
    end
  end

  // R2
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    led_clk |-> hi_run < HI_LIM);

  // R2
  burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> rises <= FW_LIM);

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(busy)) |-> !led_clk);

  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    led_clk |-> $stable(led_data));

  // R8
  crc_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crc_set |=> crc_flag);

  // R8
  crc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_clr && !crc_set) |=> !crc_flag);

  // R9
  par_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_set |=> par_flag);

  // R9
  par_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_set && !par_clr) |=> $stable(par_flag));
endmodule

bind led_status_shifter led_status_shifter_chk #(
  .FW(FRAME_W), .HI_CYC(CLK_HI_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .led_clk(led_clk), .led_data(led_data),
  .busy(seq_busy),
  .crc_set(crc_err_set), .crc_clr(crc_err_clr), .crc_flag(crc_flag),
  .par_set(par_err_set), .par_clr(par_err_clr), .par_flag(par_flag)
);

// File: tb/led_status_shifter_tb.sv
module led_status_shifter_tb;
  localparam int NP  = 34;
  localparam int NSW = 12;
  localparam int HI  = 2;
  localparam int LO  = 3;
  localparam int PER = HI + LO;
  localparam int BP  = 200;
  localparam int WP  = 40;
  localparam int FW  = NP + 2 + NSW;
  localparam int NBURST = 30;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [NP-1:0] port_link = '0, port_act = '0;
  logic          flow_active = 1'b0, sw_fault = 1'b0, lamp_test = 1'b0;
  logic          crc_err_set = 1'b0, crc_err_clr = 1'b0;
  logic          par_err_set = 1'b0, par_err_clr = 1'b0;
  logic [NSW-1:0] sw_leds = '0;
  logic          led_clk, led_data;

  led_status_shifter #(
    .NUM_PORTS(NP), .NUM_SW(NSW), .CLK_HI_CYC(HI), .CLK_LO_CYC(LO),
    .BURST_PERIODS(BP), .WINDOW_PERIODS(WP)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .port_link(port_link), .port_act(port_act),
    .flow_active(flow_active), .crc_err_set(crc_err_set), .crc_err_clr(crc_err_clr),
    .par_err_set(par_err_set), .par_err_clr(par_err_clr), .sw_fault(sw_fault),
    .sw_leds(sw_leds), .lamp_test(lamp_test), .led_clk(led_clk), .led_data(led_data)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- monitor ----------------
  logic prev_c = 1'b0, prev_d = 1'b1;
  int hi_len = 0, last_rise = 0, first_rise = 0, nrise = 0, rel = 0;
  bit hv = 0, in_burst = 0, burst_ready = 0, timing_ok = 1, hold_ok = 1, idle_ok = 1;
  int rst_rises = 0;
  bit rst_ok = 1;
  int nbursts_seen = 0;
  logic [FW-1:0] cap;

  always @(negedge clk) begin
    if (!rst_n) begin
      if (led_clk && !prev_c) begin rst_rises++; hi_len = 0; hv = 1; end
      if (led_clk) hi_len++;
      if (!led_clk && prev_c && hv && hi_len != HI) rst_ok = 0;
      if (!led_data) rst_ok = 0;
    end else if (cyc > rel + 8) begin
      if (led_clk && !prev_c) begin
        if (!in_burst) begin
          in_burst = 1; nrise = 0; first_rise = cyc; timing_ok = 1; cap = '0;
        end else if (cyc - last_rise != PER) timing_ok = 0;
        if (nrise < FW) cap[nrise] = led_data;
        nrise++;
        last_rise = cyc; hi_len = 0;
      end
      if (led_clk) hi_len++;
      if (led_clk && prev_c && led_data != prev_d) hold_ok = 0;
      if (!led_clk && prev_c && in_burst && hi_len != HI) timing_ok = 0;
      if (in_burst && !led_clk && cyc - last_rise > 3 * PER) begin
        in_burst = 0; burst_ready = 1; nbursts_seen++;
      end
      if (!in_burst && nbursts_seen > 0 && cyc - first_rise > 260 &&
          cyc - first_rise < BP * PER - 20 && (led_clk || !led_data)) idle_ok = 0;
    end
    prev_c = led_clk;
    prev_d = led_data;
  end

  // ---------------- model ----------------
  function automatic logic [FW-1:0] exp_lit(
      input logic [NP-1:0] lk, input logic [NP-1:0] ac, input bit bl,
      input bit fl, input bit flt, input logic [NSW-1:0] sw, input bit lamp);
    logic [FW-1:0] f;
    for (int k = 0; k < NP; k++) f[k] = lk[k] & (~ac[k] | bl);
    f[NP]     = fl;
    f[NP + 1] = flt;
    for (int j = 0; j < NSW; j++) f[NP + 2 + j] = sw[j];
    if (lamp) f = '1;
    return f;
  endfunction

  bit m_crc = 0, m_par = 0;
  logic [NP-1:0] act_cur = '0, act_next = '0;

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic fault_op(input bit cs, input bit cc, input bit ps, input bit pc);
    crc_err_set = cs; crc_err_clr = cc; par_err_set = ps; par_err_clr = pc;
    @(negedge clk);
    crc_err_set = 0; crc_err_clr = 0; par_err_set = 0; par_err_clr = 0;
    m_crc = cs ? 1'b1 : (cc ? 1'b0 : m_crc);
    m_par = ps ? 1'b1 : (pc ? 1'b0 : m_par);
  endtask

  task automatic pulse_act(input logic [NP-1:0] v);
    port_act = v;
    @(negedge clk);
    port_act = '0;
  endtask

  task automatic set_inputs(input int m);
    port_link   = {$urandom, $urandom};
    flow_active = $urandom_range(0, 1);
    sw_fault    = ($urandom_range(0, 3) == 0);
    sw_leds     = NSW'($urandom);
    lamp_test   = ($urandom_range(0, 7) == 0) || (m == 5);
    act_next    = {$urandom, $urandom};
    if (m == 2 || m == 3) begin port_link = '1; act_next = '1; lamp_test = 0; end
    if (m == 4) begin port_link = '0; lamp_test = 0; end
    if (m == 6) begin port_link = '1; act_next = '0; lamp_test = 0; end
  endtask

  // ---------------- main ----------------
  initial begin
    logic [FW-1:0] e;
    int prev_first;
    bit bl;
    void'($urandom(32'd2718));
    repeat (40) @(negedge clk);
    chk(rst_ok, "R1", "reset pulse width / data high", 64'(rst_ok), 64'd1);
    chk(rst_rises >= 6, "R1", "clock runs in reset", 64'(rst_rises), 64'd6);
    chk(led_data == 1'b1, "R1", "data level in reset", 64'(led_data), 64'd1);
    rst_n = 1'b1;
    rel = cyc;
    set_inputs(1);
    act_next = '0;   // nothing precedes the first burst
    prev_first = 0;
    for (int m = 1; m <= NBURST; m++) begin
      while (!burst_ready) @(negedge clk);
      burst_ready = 0;
      act_cur = act_next;
      bl = (m % 2) == 1;
      e = exp_lit(port_link, act_cur, bl, flow_active, m_crc | m_par | sw_fault,
                  sw_leds, lamp_test);
      chk(nrise == FW, "R2", "edges per burst", 64'(nrise), 64'(FW));
      chk(timing_ok, "R2", "pulse width / spacing", 64'(timing_ok), 64'd1);
      chk(hold_ok, "R4", "data stable while clock high", 64'(hold_ok), 64'd1);
      if (m > 1) begin
        chk(first_rise - prev_first == BP * PER, "R3", "burst interval",
            64'(first_rise - prev_first), 64'(BP * PER));
        chk(idle_ok, "R3", "idle line between bursts", 64'(idle_ok), 64'd1);
      end
      chk(cap[NP-1:0] == ~e[NP-1:0], "R6 R7 R5 R4", $sformatf("port slots burst %0d", m),
          64'(cap[NP-1:0]), 64'(~e[NP-1:0]));
      chk(cap[NP] == ~e[NP], "R11", "congestion slot", 64'(cap[NP]), 64'(~e[NP]));
      chk(cap[NP+1] == ~e[NP+1], "R10 R8 R9", "fault slot", 64'(cap[NP+1]), 64'(~e[NP+1]));
      chk(cap[FW-1:NP+2] == ~e[FW-1:NP+2], "R11", "software slots",
          64'(cap[FW-1:NP+2]), 64'(~e[FW-1:NP+2]));
      if (lamp_test) chk(cap == '0, "R12", "lamp test frame", 64'(cap), 64'd0);
      hold_ok = 1; idle_ok = 1;
      prev_first = first_rise;

      wait_until(first_rise + 300);
      set_inputs(m + 1);
      if (m == 3) begin   // directed: set and clear together, set wins
        fault_op(0, 1, 0, 1);
        fault_op(1, 1, 1, 1);
      end else if (m == 4) begin
        fault_op(0, 1, 0, 0);
      end else if (m == 7) begin
        fault_op(0, 0, 0, 1);
      end else if (m % 3 == 0) begin
        for (int i = 0; i < 4; i++)
          fault_op($urandom_range(0, 3) == 0, $urandom_range(0, 2) == 0,
                   $urandom_range(0, 3) == 0, $urandom_range(0, 2) == 0);
      end
      wait_until(first_rise + 496);
      pulse_act({$urandom, $urandom});   // older window, must be forgotten
      wait_until(first_rise + 696);
      pulse_act(act_next);
      wait_until(first_rise + 896);
      pulse_act({$urandom, $urandom});   // window closing at burst start
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    while (cyc < 120000) @(negedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule